// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the write-side command interpreter for a parallel NOR-style flash memory model. It sees one bus write per clock when `wr_en` is high. It follows the multi-write unlock handshakes that guard every state-changing command. From these handshakes it decides whether the memory shows array data, identifier data or program status.

A complete program handshake latches the target address and data. The block then raises a one-cycle protection query. If the target block is not protected, it pulses `prog_go` and stays busy until the external program engine reports `prog_done` together with a pass or fail result.

Only the low eleven word-address bits, the byte-select bit (in byte mode) and the low data byte take part in command matching. Any write that breaks an expected step drops the decoder back to array-read mode.

Top module: `nor_cmd_decoder`

## Requirements
- R1: A synchronous reset (`rst_n` low at a rising edge) puts the block in read mode. It discards any partial handshake, clears the error state and leaves `prog_go` low. Exactly one of the five mode outputs is high at all times.
- R2: In word mode, three writes enter identifier mode. They are 0xAA at 0x555, then 0x55 at 0x2AA, then 0x90 at 0x555. Identifier mode stays while no writes arrive. It also stays shown while a new handshake is partly entered.
- R3: Program is four writes: the unlock pair, then 0xA0 at 0x555, then the target. The cycle after the target write, `prot_req` is high and `prog_addr`/`prog_data` hold that write. If `prot_hit` is low in that cycle, `prog_go` pulses high for one cycle on the next edge and `mode_busy` holds.
- R4: If `prot_hit` is high while `prot_req` is high, the program is dropped without a trace. The block returns to the mode it came from, with no `prog_go` and no error.
- R5: While busy, every write is ignored, including 0xF0. A `prog_done` with `prog_fail` low ends the operation. A `prog_done` with `prog_fail` high enters the error mode instead.
- R6: In error mode, only a single write with low data byte 0xF0 (any address) leaves the mode, and it goes to read mode. All other writes are ignored.
- R7: Read/reset is accepted in two forms. One is a single write of 0xF0 to any address. The other is the unlock pair followed by 0xF0 at 0x555. Either form leaves identifier mode for read mode.
- R8: Any write whose address or data does not fit the next expected step returns the block to read mode. This also clears identifier mode.
- R9: Only address bits 0..10 and data bits 0..7 are compared. Higher address bits and data bits 8..15 never change the decode.
- R10: With `byte_mode` high, the byte-select input `wr_lsb` joins the compared address as its new bit 0. 0x555 then needs `wr_lsb`=0, and 0x2AA needs `wr_lsb`=1. In word mode `wr_lsb` is ignored. `prog_addr` is `{wr_addr, wr_lsb}` in byte mode and `{wr_addr, 0}` in word mode.
- R11: The unlock pair followed by 0x20 at 0x555 enters bypass mode. In bypass mode, 0xA0 at any address followed by a target write runs a program, and completion returns to bypass. 0x90 followed by 0x00 (any addresses) leaves for read mode. Any other write leaves bypass mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_mode | input | 1 | 1 = 8-bit bus organisation |
| wr_en | input | 1 | A bus write occurs this cycle |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_lsb | input | 1 | Byte select, used as address bit -1 in byte mode |
| wr_data | input | DATA_W | Write data |
| prot_hit | input | 1 | Target block is protected (sampled while `prot_req`) |
| prog_done | input | 1 | Program engine finished |
| prog_fail | input | 1 | Qualifies `prog_done` as a failure |
| mode_read | output | 1 | Array read mode |
| mode_ident | output | 1 | Identifier mode |
| mode_bypass | output | 1 | Unlock-bypass mode |
| mode_busy | output | 1 | Program checking or running |
| mode_error | output | 1 | Failed program, status shown |
| prot_req | output | 1 | Protection query for `prog_addr` |
| prog_go | output | 1 | One-cycle program start |
| prog_addr | output | ADDR_W+1 | Latched target, byte select in bit 0 |
| prog_data | output | DATA_W | Latched program data |

## Verification
The bench targets these corner cases and the failure each one exposes:
- A reset in the middle of a handshake. A decoder that kept the partial state would reach identifier mode from a shortened sequence.
- An 0xF0 write while busy. A decoder that honoured it would abort a program that must not be stopped.
- A protected target. A decoder that got this wrong would pulse `prog_go` or raise an error.
- A failed program followed by stray writes. A decoder that got this wrong would leave error mode on writes that are not 0xF0.
- Command writes with noisy high address and data bits, and byte-mode addresses with the wrong byte select. These catch decoders that compare too many bits, or too few.
- Bypass programs, to confirm that completion returns to bypass rather than read mode.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_CYC1    = 4'd1,
        ST_CYC2    = 4'd2,
        ST_ARM     = 4'd3,
        ST_BYP     = 4'd4,
        ST_BYP_ARM = 4'd5,
        ST_BYP_RST = 4'd6,
        ST_CHECK   = 4'd7,
        ST_BUSY    = 4'd8,
        ST_ERROR   = 4'd9
    } seq_state_e;

    localparam int CODE_W = 8;

    localparam logic [CODE_W-1:0] CODE_UNL1     = 8'hAA;
    localparam logic [CODE_W-1:0] CODE_UNL2     = 8'h55;
    localparam logic [CODE_W-1:0] CODE_IDENT    = 8'h90;
    localparam logic [CODE_W-1:0] CODE_PROG     = 8'hA0;
    localparam logic [CODE_W-1:0] CODE_BYP      = 8'h20;
    localparam logic [CODE_W-1:0] CODE_RESET    = 8'hF0;
    localparam logic [CODE_W-1:0] CODE_BYP_EXIT = 8'h00;

    typedef struct packed {
        logic rd;
        logic id;
        logic byp;
        logic busy;
        logic err;
    } mode_t;

endpackage

// File: rtl/nor_cmd_match.sv
module nor_cmd_match #(
    parameter int              CMD_BITS   = 11,
    parameter logic [10:0]     FIRST_SLOT = 11'h555,
    parameter logic [10:0]     SECOND_SLOT = 11'h2AA
) (
    input  logic [CMD_BITS-1:0] addr_lo,
    input  logic                lsb,
    input  logic                byte_mode,
    output logic                hit_first,
    output logic                hit_second
);
    localparam logic [CMD_BITS-1:0] FIRST_W  = FIRST_SLOT[CMD_BITS-1:0];
    localparam logic [CMD_BITS-1:0] SECOND_W = SECOND_SLOT[CMD_BITS-1:0];

    // In byte mode the byte select becomes the new bit 0 of the compared
    // address: first slot needs it low, second slot needs it high.
    always_comb begin
        hit_first  = (addr_lo == FIRST_W)  && (!byte_mode || !lsb);
        hit_second = (addr_lo == SECOND_W) && (!byte_mode ||  lsb);
    end
endmodule

// File: rtl/nor_cmd_outdec.sv
module nor_cmd_outdec
    import nor_cmd_pkg::*;
(
    input  seq_state_e st,
    input  logic       ident,
    output mode_t      mode,
    output logic       query
);
    logic readable;

    always_comb begin
        readable  = (st == ST_IDLE) || (st == ST_CYC1) ||
                    (st == ST_CYC2) || (st == ST_ARM);
        mode.rd   = readable && !ident;
        mode.id   = readable &&  ident;
        mode.byp  = (st == ST_BYP) || (st == ST_BYP_ARM) || (st == ST_BYP_RST);
        mode.busy = (st == ST_CHECK) || (st == ST_BUSY);
        mode.err  = (st == ST_ERROR);
        query     = (st == ST_CHECK);
    end
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 16,
    parameter int CMD_BITS = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_lsb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              prot_hit,
    input  logic              prog_done,
    input  logic              prog_fail,
    output logic              mode_read,
    output logic              mode_ident,
    output logic              mode_bypass,
    output logic              mode_busy,
    output logic              mode_error,
    output logic              prot_req,
    output logic              prog_go,
    output logic [ADDR_W:0]   prog_addr,
    output logic [DATA_W-1:0] prog_data
);
    localparam int PA_W = ADDR_W + 1;

    typedef struct packed {
        seq_state_e        st;
        logic              ident;
        logic              ret_byp;
        logic              go;
        logic [PA_W-1:0]   addr;
        logic [DATA_W-1:0] data;
    } regs_t;

    regs_t r_q, r_d;

    logic               hit_first, hit_second;
    logic [CODE_W-1:0]  code;
    logic [PA_W-1:0]    addr_full;
    mode_t              mode;

    nor_cmd_match #(.CMD_BITS(CMD_BITS)) u_match (
        .addr_lo   (wr_addr[CMD_BITS-1:0]),
        .lsb       (wr_lsb),
        .byte_mode (byte_mode),
        .hit_first (hit_first),
        .hit_second(hit_second)
    );

    nor_cmd_outdec u_outdec (
        .st    (r_q.st),
        .ident (r_q.ident),
        .mode  (mode),
        .query (prot_req)
    );

    assign code      = wr_data[CODE_W-1:0];
    assign addr_full = {wr_addr, byte_mode & wr_lsb};

    always_comb begin
        r_d    = r_q;
        r_d.go = 1'b0;
        unique case (r_q.st)
            ST_IDLE: if (wr_en) begin
                if (hit_first && code == CODE_UNL1) r_d.st = ST_CYC1;
                else                                r_d.ident = 1'b0;
            end
            ST_CYC1: if (wr_en) begin
                if (hit_second && code == CODE_UNL2) r_d.st = ST_CYC2;
                else begin
                    r_d.st    = ST_IDLE;
                    r_d.ident = 1'b0;
                end
            end
            ST_CYC2: if (wr_en) begin
                r_d.st    = ST_IDLE;
                r_d.ident = 1'b0;
                if (hit_first) begin
                    case (code)
                        CODE_IDENT: r_d.ident = 1'b1;
                        CODE_PROG:  r_d.st    = ST_ARM;
                        CODE_BYP:   r_d.st    = ST_BYP;
                        default:    ;
                    endcase
                end
            end
            ST_ARM: if (wr_en) begin
                r_d.st      = ST_CHECK;
                r_d.addr    = addr_full;
                r_d.data    = wr_data;
                r_d.ret_byp = 1'b0;
            end
            ST_BYP: if (wr_en) begin
                if (code == CODE_PROG)       r_d.st = ST_BYP_ARM;
                else if (code == CODE_IDENT) r_d.st = ST_BYP_RST;
            end
            ST_BYP_ARM: if (wr_en) begin
                r_d.st      = ST_CHECK;
                r_d.addr    = addr_full;
                r_d.data    = wr_data;
                r_d.ret_byp = 1'b1;
            end
            ST_BYP_RST: if (wr_en) begin
                r_d.st    = (code == CODE_BYP_EXIT) ? ST_IDLE : ST_BYP;
                r_d.ident = 1'b0;
            end
            ST_CHECK: begin
                if (prot_hit) r_d.st = r_q.ret_byp ? ST_BYP : ST_IDLE;
                else begin
                    r_d.st = ST_BUSY;
                    r_d.go = 1'b1;
                end
            end
            ST_BUSY: if (prog_done) begin
                if (prog_fail) r_d.st = ST_ERROR;
                else           r_d.st = r_q.ret_byp ? ST_BYP : ST_IDLE;
            end
            ST_ERROR: if (wr_en && code == CODE_RESET) r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mode_read   = mode.rd;
    assign mode_ident  = mode.id;
    assign mode_bypass = mode.byp;
    assign mode_busy   = mode.busy;
    assign mode_error  = mode.err;
    assign prog_go     = r_q.go;
    assign prog_addr   = r_q.addr;
    assign prog_data   = r_q.data;

    // Assertions
    assert_one_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mode_read, mode_ident, mode_bypass, mode_busy, mode_error}) == 1);

    assert_go_after_query_R3: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> ($past(prot_req) && !$past(prot_hit)));

    assert_target_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_busy && $past(mode_busy)) |-> ($stable(prog_addr) && $stable(prog_data)));

    assert_protected_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_req && prot_hit) |=> (!mode_busy && !prog_go && !mode_error));

    assert_busy_deaf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_busy && !prot_req && !prog_done) |=> mode_busy);

    assert_error_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_error && !(wr_en && wr_data[CODE_W-1:0] == CODE_RESET)) |=> mode_error);

endmodule

// File: tb/sim_nor_cmd_decoder.sv
module sim_nor_cmd_decoder;
    localparam int  CLK_PERIOD = 10;
    localparam int  AW = 18;
    localparam int  DW = 16;

    localparam logic [4:0] M_RD = 5'b10000;
    localparam logic [4:0] M_ID = 5'b01000;
    localparam logic [4:0] M_BP = 5'b00100;
    localparam logic [4:0] M_BZ = 5'b00010;
    localparam logic [4:0] M_ER = 5'b00001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic byte_mode = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic wr_lsb = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic prot_hit = 1'b0;
    logic prog_done = 1'b0;
    logic prog_fail = 1'b0;
    logic mode_read, mode_ident, mode_bypass, mode_busy, mode_error;
    logic prot_req, prog_go;
    logic [AW:0] prog_addr;
    logic [DW-1:0] prog_data;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [4:0]  m;
        logic        req;
        logic        go;
        bit          ad;
        logic [AW:0] a;
        logic [DW-1:0] d;
        string       tag;
    } exp_t;

    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_lsb(wr_lsb), .wr_data(wr_data),
        .prot_hit(prot_hit), .prog_done(prog_done), .prog_fail(prog_fail),
        .mode_read(mode_read), .mode_ident(mode_ident), .mode_bypass(mode_bypass),
        .mode_busy(mode_busy), .mode_error(mode_error), .prot_req(prot_req),
        .prog_go(prog_go), .prog_addr(prog_addr), .prog_data(prog_data)
    );

    // Monitor: compare queued expectations half a cycle after the edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                logic [4:0] m;
                e = q.pop_front();
                m = {mode_read, mode_ident, mode_bypass, mode_busy, mode_error};
                n_chk++;
                if (m !== e.m || prot_req !== e.req || prog_go !== e.go) begin
                    n_fail++;
                    $display("FAIL %s: modes=%b req=%b go=%b, expected modes=%b req=%b go=%b",
                             e.tag, m, prot_req, prog_go, e.m, e.req, e.go);
                end
                if (e.ad) begin
                    n_chk++;
                    if (prog_addr !== e.a || prog_data !== e.d) begin
                        n_fail++;
                        $display("FAIL %s: addr=%h data=%h, expected addr=%h data=%h",
                                 e.tag, prog_addr, prog_data, e.a, e.d);
                    end
                end
            end
        end
    end

    task automatic push(input logic [4:0] m, input logic rq, input logic g, input string t);
        exp_t e;
        e.m = m; e.req = rq; e.go = g; e.ad = 1'b0; e.a = '0; e.d = '0; e.tag = t;
        q.push_back(e);
    endtask

    task automatic push_ad(input logic [4:0] m, input logic rq, input logic g,
                           input logic [AW:0] a, input logic [DW-1:0] d, input string t);
        exp_t e;
        e.m = m; e.req = rq; e.go = g; e.ad = 1'b1; e.a = a; e.d = d; e.tag = t;
        q.push_back(e);
    endtask

    task automatic cyc(input logic w, input logic [AW-1:0] a, input logic l, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = w; wr_addr = a; wr_lsb = l; wr_data = d;
        prog_done = 1'b0; prog_fail = 1'b0;
        @(posedge clk);
    endtask

    task automatic idle();
        cyc(1'b0, '0, 1'b0, '0);
    endtask

    task automatic done_cyc(input logic f);
        @(negedge clk);
        wr_en = 1'b0; prog_done = 1'b1; prog_fail = f;
        @(posedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; prog_done = 1'b0; prog_fail = 1'b0;
        @(posedge clk);
        push(M_RD, 1'b0, 1'b0, "R1 reset state");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic unlock();
        cyc(1'b1, 18'h00555, 1'b0, 16'h00AA);
        cyc(1'b1, 18'h002AA, 1'b0, 16'h0055);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();

        // R2 identifier entry and persistence
        unlock();
        cyc(1'b1, 18'h00555, 1'b0, 16'h0090);
        push(M_ID, 0, 0, "R2 ident entry");
        idle(); idle(); idle();
        push(M_ID, 0, 0, "R2 ident persists");
        cyc(1'b1, 18'h00555, 1'b0, 16'h00AA);
        push(M_ID, 0, 0, "R2 ident during prefix 1");
        cyc(1'b1, 18'h002AA, 1'b0, 16'h0055);
        push(M_ID, 0, 0, "R2 ident during prefix 2");
        // R7 three-write reset
        cyc(1'b1, 18'h00555, 1'b0, 16'h00F0);
        push(M_RD, 0, 0, "R7 long reset");

        // R7 single-write reset from ident
        unlock();
        cyc(1'b1, 18'h00555, 1'b0, 16'h0090);
        cyc(1'b1, 18'h01234, 1'b0, 16'h00F0);
        push(M_RD, 0, 0, "R7 short reset");

        // R8 deviations
        unlock();
        cyc(1'b1, 18'h00555, 1'b0, 16'h0090);
        cyc(1'b1, 18'h00555, 1'b0, 16'h00AA);
        cyc(1'b1, 18'h002AB, 1'b0, 16'h0055);
        push(M_RD, 0, 0, "R8 wrong second address");
        cyc(1'b1, 18'h00555, 1'b0, 16'h00AA);
        cyc(1'b1, 18'h002AA, 1'b0, 16'h0056);
        cyc(1'b1, 18'h00555, 1'b0, 16'h0090);
        push(M_RD, 0, 0, "R8 wrong second data");
        unlock();
        cyc(1'b1, 18'h00554, 1'b0, 16'h0090);
        push(M_RD, 0, 0, "R8 wrong third address");

        // R1 reset in mid-handshake
        cyc(1'b1, 18'h00555, 1'b0, 16'h00AA);
        do_reset();
        cyc(1'b1, 18'h002AA, 1'b0, 16'h0055);
        cyc(1'b1, 18'h00555, 1'b0, 16'h0090);
        push(M_RD, 0, 0, "R1 partial handshake dropped");

        // R9 don't-care bits
        cyc(1'b1, 18'h3F555, 1'b0, 16'hFFAA);
        cyc(1'b1, 18'h3FAAA, 1'b0, 16'h1255);
        cyc(1'b1, 18'h2D555, 1'b0, 16'hAB90);
        push(M_ID, 0, 0, "R9 noisy upper bits");
        cyc(1'b1, 18'h3FFFF, 1'b0, 16'hA5F0);
        push(M_RD, 0, 0, "R9 noisy reset");

        // R3 program, R5 busy ignores writes
        prot_hit = 1'b0;
        unlock();
        cyc(1'b1, 18'h00555, 1'b0, 16'h00A0);
        push(M_RD, 0, 0, "R3 armed");
        cyc(1'b1, 18'h12345, 1'b1, 16'hBEEF);
        push_ad(M_BZ, 1, 0, {18'h12345, 1'b0}, 16'hBEEF, "R3 query");
        idle();
        push(M_BZ, 0, 1, "R3 go pulse");
        idle();
        push(M_BZ, 0, 0, "R3 go ends");
        cyc(1'b1, 18'h00000, 1'b0, 16'h00F0);
        push(M_BZ, 0, 0, "R5 reset ignored while busy");
        cyc(1'b1, 18'h00555, 1'b0, 16'h00AA);
        push_ad(M_BZ, 0, 0, {18'h12345, 1'b0}, 16'hBEEF, "R5 write ignored while busy");
        done_cyc(1'b0);
        push(M_RD, 0, 0, "R5 pass returns to read");

        // R5 fail, R6 error exit
        unlock();
        cyc(1'b1, 18'h00555, 1'b0, 16'h00A0);
        cyc(1'b1, 18'h00100, 1'b0, 16'h0000);
        idle();
        done_cyc(1'b1);
        push(M_ER, 0, 0, "R5 fail enters error");
        cyc(1'b1, 18'h002AA, 1'b0, 16'h0055);
        push(M_ER, 0, 0, "R6 non-reset ignored");
        cyc(1'b1, 18'h00555, 1'b0, 16'h00AA);
        push(M_ER, 0, 0, "R6 prefix ignored");
        cyc(1'b1, 18'h00777, 1'b0, 16'h00F0);
        push(M_RD, 0, 0, "R6 reset clears error");

        // R4 protected target
        prot_hit = 1'b1;
        unlock();
        cyc(1'b1, 18'h00555, 1'b0, 16'h00A0);
        cyc(1'b1, 18'h3C000, 1'b0, 16'h1234);
        push(M_BZ, 1, 0, "R4 query");
        idle();
        push(M_RD, 0, 0, "R4 dropped silently");
        idle();
        push(M_RD, 0, 0, "R4 no late go");
        prot_hit = 1'b0;

        // R10 byte mode
        byte_mode = 1'b1;
        cyc(1'b1, 18'h00555, 1'b0, 16'h00AA);
        cyc(1'b1, 18'h002AA, 1'b0, 16'h0055);
        cyc(1'b1, 18'h00555, 1'b0, 16'h0090);
        push(M_RD, 0, 0, "R10 byte mode needs select high on second");
        cyc(1'b1, 18'h00555, 1'b0, 16'h00AA);
        cyc(1'b1, 18'h002AA, 1'b1, 16'h0055);
        cyc(1'b1, 18'h00555, 1'b0, 16'h00A0);
        cyc(1'b1, 18'h00010, 1'b1, 16'h00C3);
        push_ad(M_BZ, 1, 0, {18'h00010, 1'b1}, 16'h00C3, "R10 byte target");
        idle();
        done_cyc(1'b0);
        push(M_RD, 0, 0, "R10 byte program done");
        byte_mode = 1'b0;
        cyc(1'b1, 18'h00555, 1'b1, 16'h00AA);
        cyc(1'b1, 18'h002AA, 1'b0, 16'h0055);
        cyc(1'b1, 18'h00555, 1'b1, 16'h0090);
        push(M_ID, 0, 0, "R10 word mode ignores select");
        cyc(1'b1, 18'h00000, 1'b0, 16'h00F0);

        // R11 bypass
        unlock();
        cyc(1'b1, 18'h00555, 1'b0, 16'h0020);
        push(M_BP, 0, 0, "R11 bypass entry");
        cyc(1'b1, 18'h00100, 1'b0, 16'h0033);
        push(M_BP, 0, 0, "R11 stray write ignored");
        cyc(1'b1, 18'h00007, 1'b0, 16'h00A0);
        cyc(1'b1, 18'h2AAAA, 1'b0, 16'h1111);
        push_ad(M_BZ, 1, 0, {18'h2AAAA, 1'b0}, 16'h1111, "R11 bypass program query");
        idle();
        push(M_BZ, 0, 1, "R11 bypass go");
        done_cyc(1'b0);
        push(M_BP, 0, 0, "R11 back to bypass");
        cyc(1'b1, 18'h00001, 1'b0, 16'h0090);
        cyc(1'b1, 18'h00001, 1'b0, 16'h0012);
        push(M_BP, 0, 0, "R11 bad exit stays bypass");
        cyc(1'b1, 18'h00001, 1'b0, 16'h0090);
        cyc(1'b1, 18'h00002, 1'b0, 16'h0000);
        push(M_RD, 0, 0, "R11 bypass exit");

        // R1 reset while busy
        unlock();
        cyc(1'b1, 18'h00555, 1'b0, 16'h00A0);
        cyc(1'b1, 18'h00042, 1'b0, 16'h4242);
        idle();
        do_reset();

        idle();
        @(negedge clk);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule